// File: doc/BRIEF.md
# Line Latch with Polarity Output Control

This block sits between the column data register of a display source driver and its gray-level output stage. When the line strobe rises, it copies the whole loaded line into a holding latch and samples the polarity input. While the strobe stays high, the output stage is released. On the falling edge of the strobe, the newly held line is presented and drive is restored. Each column then carries four things:

- its 6-bit gray code;
- a flag that picks the upper or lower reference group;
- the gamma segment index that a resistor-string converter model needs;
- the tap offset within that segment.

The reference group alternates between neighbouring columns. The polarity input swaps the assignment line by line, so the panel sees inverted drive on each line. A monitor checks that polarity was held steady for a set number of clocks before each strobe rising edge. It keeps a sticky flag when this rule is broken.

All inputs are sampled on the block clock. The strobe is an ordinary synchronous input, and its edges are found by comparing it with its value on the previous clock.

Top module: `line_latch_polctl`

## Requirements
- R1: At the first clock edge that samples `strobe` high after a low, all of `line_in` is copied into the line latch. Later changes of `line_in` never reach the outputs before the next such edge.
- R2: At every clock edge that samples `strobe` high, `out_en` becomes 0, and it stays 0 for as long as `strobe` is sampled high.
- R3: At the first edge that samples `strobe` low after a high, `out_en` becomes 1 and the column outputs take the latched line. At every other edge the column outputs hold their values, so idle changes on `line_in` are ignored.
- R4: `grp_lower[j]` is 1 when column j uses the lower reference group and 0 for the upper group. For column j (0-based, so even j is an odd-numbered output), the value is the captured polarity XOR bit 0 of j.
- R5: Polarity is captured at the strobe rising edge. Changes of `pol` after that edge do not affect the group selects of the current line.
- R6: `seg_idx` of a column is code bits [5:4]: codes 0x00–0x0F give segment 0, 0x10–0x1F give 1, 0x20–0x2F give 2, and 0x30–0x3F give 3.
- R7: For the upper group, `tap_off` is code bits [3:0]. The boundary codes 0x10, 0x20 and 0x30 give tap 0 of segments 1, 2 and 3, and 0x3F gives tap 15 of segment 3, which is its end reference.
- R8: For the lower group, the tap is mirrored: `tap_off` = span − code[3:0]. The span is 16 in segments 0 to 2 and 15 in segment 3.
- R9: At a strobe rising edge, `pol` must equal its value at each of the previous SETUP_CYC edges (default 2). If it does not, `setup_viol` becomes 1 and stays 1 until reset.
- R10: While `rst` is high, `out_en`, all column outputs and `setup_viol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Line strobe, one pulse per horizontal line |
| pol | input | 1 | Line polarity, captured at strobe rise |
| line_in | input | NCOL*CODE_W (48) | Loaded data register, column j at bits [j*6 +: 6] |
| out_en | output | 1 | Output drive enable (0 = released) |
| code_out | output | NCOL*CODE_W (48) | Presented gray codes per column |
| grp_lower | output | NCOL (8) | Per column: 1 = lower reference group |
| seg_idx | output | NCOL*2 (16) | Per column gamma segment index |
| tap_off | output | NCOL*(CODE_W-1) (40) | Per column tap offset within the segment |
| setup_viol | output | 1 | Sticky polarity setup violation |

## Verification
The assertions assume three things about the inputs:

- `strobe` is held high for at least two sampled clocks.
- A new line is only loaded while outputs are not being updated.
- Reset is applied before the first strobe.

The stimulus keeps within these limits. Each strobe is high for exactly two edges, and every new line, together with its polarity, is set up while the strobe is low. Polarity is normally changed at least SETUP_CYC edges before each rising edge. It is placed deliberately inside that window only in the cases that test the violation flag.

// File: rtl/llp_pkg.sv
package llp_pkg;
  localparam int SEG_W = 2;

  typedef enum logic {
    GRP_UPPER = 1'b0,
    GRP_LOWER = 1'b1
  } grp_e;

  function automatic grp_e pick_group(input logic pol_cap, input logic col_is_odd_idx);
    return grp_e'(pol_cap ^ col_is_odd_idx);
  endfunction
endpackage

// File: rtl/llp_strobe_seq.sv
module llp_strobe_seq (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise,
  output logic fall,
  output logic out_en
);
  logic stb_q;

  assign rise = strobe & ~stb_q;
  assign fall = ~strobe & stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q  <= 1'b0;
      out_en <= 1'b0;
    end else begin
      stb_q <= strobe;
      if (strobe)    out_en <= 1'b0;
      else if (fall) out_en <= 1'b1;
    end
  end
endmodule

// File: rtl/llp_line_store.sv
module llp_line_store #(
  parameter int NCOL   = 8,
  parameter int CODE_W = 6,
  localparam int LW    = NCOL * CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [LW-1:0] line_in,
  input  logic          pol,
  output logic [LW-1:0] line_q,
  output logic          pol_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      pol_q  <= 1'b0;
    end else if (capture) begin
      line_q <= line_in;
      pol_q  <= pol;
    end
  end
endmodule

// File: rtl/llp_pol_setup.sv
module llp_pol_setup #(
  parameter int SETUP_CYC = 2,
  localparam int CW = $clog2(SETUP_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pol,
  input  logic rise,
  output logic viol
);
  logic          pol_prev;
  logic [CW-1:0] streak;
  logic          moved;
  logic          short_hold;

  assign moved      = (pol != pol_prev);
  assign short_hold = moved || (streak < CW'(SETUP_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_prev <= 1'b0;
      streak   <= CW'(SETUP_CYC);
      viol     <= 1'b0;
    end else begin
      pol_prev <= pol;
      if (moved)                        streak <= CW'(1);
      else if (streak < CW'(SETUP_CYC)) streak <= streak + CW'(1);
      if (rise && short_hold)           viol <= 1'b1;
    end
  end
endmodule

// File: rtl/llp_col_decode.sv
module llp_col_decode
  import llp_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int COL_IDX = 0,
  localparam int OFF_W  = CODE_W - SEG_W,
  localparam int TAP_W  = OFF_W + 1,
  localparam int FULL   = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code_i,
  input  logic              pol_i,
  output logic [CODE_W-1:0] code_o,
  output logic              lower_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic [TAP_W-1:0]  tap_o
);
  localparam logic ODD_IDX = (COL_IDX % 2) == 1;

  grp_e             grp_n;
  logic [SEG_W-1:0] seg_n;
  logic [TAP_W-1:0] off_n, span_n, tap_n;

  always_comb begin
    grp_n  = pick_group(pol_i, ODD_IDX);
    seg_n  = code_i[CODE_W-1 -: SEG_W];
    off_n  = {1'b0, code_i[OFF_W-1:0]};
    span_n = (seg_n == '1) ? TAP_W'(FULL - 1) : TAP_W'(FULL);
    tap_n  = (grp_n == GRP_LOWER) ? (span_n - off_n) : off_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o  <= '0;
      lower_o <= 1'b0;
      seg_o   <= '0;
      tap_o   <= '0;
    end else if (load) begin
      code_o  <= code_i;
      lower_o <= (grp_n == GRP_LOWER);
      seg_o   <= seg_n;
      tap_o   <= tap_n;
    end
  end
endmodule

// File: rtl/line_latch_polctl.sv
module line_latch_polctl
  import llp_pkg::*;
#(
  parameter int NCOL      = 8,
  parameter int CODE_W    = 6,
  parameter int SETUP_CYC = 2,
  localparam int LW       = NCOL * CODE_W,
  localparam int TAP_W    = CODE_W - SEG_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  strobe,
  input  logic                  pol,
  input  logic [LW-1:0]         line_in,
  output logic                  out_en,
  output logic [LW-1:0]         code_out,
  output logic [NCOL-1:0]       grp_lower,
  output logic [NCOL*SEG_W-1:0] seg_idx,
  output logic [NCOL*TAP_W-1:0] tap_off,
  output logic                  setup_viol
);
  logic          rise, fall, pol_cap;
  logic [LW-1:0] line_q;

  llp_strobe_seq u_seq (
    .clk(clk), .rst(rst), .strobe(strobe),
    .rise(rise), .fall(fall), .out_en(out_en)
  );

  llp_line_store #(.NCOL(NCOL), .CODE_W(CODE_W)) u_store (
    .clk(clk), .rst(rst), .capture(rise), .line_in(line_in), .pol(pol),
    .line_q(line_q), .pol_q(pol_cap)
  );

  llp_pol_setup #(.SETUP_CYC(SETUP_CYC)) u_setup (
    .clk(clk), .rst(rst), .pol(pol), .rise(rise), .viol(setup_viol)
  );

  for (genvar j = 0; j < NCOL; j++) begin : g_col
    llp_col_decode #(.CODE_W(CODE_W), .COL_IDX(j)) u_dec (
      .clk(clk), .rst(rst), .load(fall),
      .code_i(line_q[j*CODE_W +: CODE_W]), .pol_i(pol_cap),
      .code_o(code_out[j*CODE_W +: CODE_W]), .lower_o(grp_lower[j]),
      .seg_o(seg_idx[j*SEG_W +: SEG_W]), .tap_o(tap_off[j*TAP_W +: TAP_W])
    );
  end
endmodule

// File: rtl/llp_check.sv
module llp_check #(
  parameter int NCOL   = 8,
  parameter int CODE_W = 6,
  parameter int TAP_W  = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  strobe,
  input logic                  out_en,
  input logic [NCOL*CODE_W-1:0] code_out,
  input logic [NCOL-1:0]       grp_lower,
  input logic [NCOL*TAP_W-1:0] tap_off,
  input logic                  setup_viol
);
  logic stb_d;
  always_ff @(posedge clk) begin
    if (rst) stb_d <= 1'b0;
    else     stb_d <= strobe;
  end

  assert_release_on_high_R2: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !out_en);

  assert_drive_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (!strobe && stb_d) |=> out_en);

  assert_hold_between_falls_R3: assert property (@(posedge clk) disable iff (rst)
    !(!strobe && stb_d) |=> $stable(code_out) && $stable(grp_lower));

  assert_sticky_viol_R9: assert property (@(posedge clk) disable iff (rst)
    setup_viol |=> setup_viol);

  assert_neighbour_groups_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_en) |-> (grp_lower[0] != grp_lower[1]));

  assert_upper_tap_range_R7: assert property (@(posedge clk) disable iff (rst)
    !grp_lower[0] |-> !tap_off[TAP_W-1]);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!out_en && !setup_viol));
endmodule

bind line_latch_polctl llp_check #(.NCOL(NCOL), .CODE_W(CODE_W), .TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .out_en(out_en), .code_out(code_out),
  .grp_lower(grp_lower), .tap_off(tap_off), .setup_viol(setup_viol)
);

// File: tb/sim_line_latch_polctl.sv
`timescale 1ns/1ps
module sim_line_latch_polctl;
  localparam int NCOL = 8, CODE_W = 6, SETUP_CYC = 2;
  localparam int LW = NCOL * CODE_W, TAP_W = CODE_W - 1;

  logic clk = 1'b0, rst = 1'b1, strobe = 1'b0, pol = 1'b0;
  logic [LW-1:0] line_in = '0;
  logic out_en, setup_viol;
  logic [LW-1:0] code_out;
  logic [NCOL-1:0] grp_lower;
  logic [NCOL*2-1:0] seg_idx;
  logic [NCOL*TAP_W-1:0] tap_off;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [LW-1:0] shown = '0;

  always #2.5 clk = ~clk;

  line_latch_polctl #(.NCOL(NCOL), .CODE_W(CODE_W), .SETUP_CYC(SETUP_CYC)) u0 (
    .clk(clk), .rst(rst), .strobe(strobe), .pol(pol), .line_in(line_in),
    .out_en(out_en), .code_out(code_out), .grp_lower(grp_lower),
    .seg_idx(seg_idx), .tap_off(tap_off), .setup_viol(setup_viol)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; strobe = 1'b0; pol = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 out_en", out_en, 0);
    chk("R10 code_out", code_out, 0);
    chk("R10 grp_lower", grp_lower, 0);
    chk("R10 setup_viol", setup_viol, 0);
    rst = 1'b0; shown = '0;
  endtask

  task automatic check_columns(input logic [LW-1:0] data, input logic p);
    for (int j = 0; j < NCOL; j++) begin
      int c, s, lo, t;
      c  = int'(data[j*CODE_W +: CODE_W]);
      s  = c >> 4;
      lo = int'(p) ^ (j & 1);
      t  = lo ? (((s == 3) ? 15 : 16) - (c & 15)) : (c & 15);
      chk("R1 code", code_out[j*CODE_W +: CODE_W], c);
      chk("R4 R5 group", grp_lower[j], lo);
      chk("R6 segment", seg_idx[j*2 +: 2], s);
      chk(lo ? "R8 tap" : "R7 tap", tap_off[j*TAP_W +: TAP_W], t);
    end
  endtask

  task automatic run_line(input logic [LW-1:0] data, input logic p, input int d);
    @(negedge clk); line_in = data; pol = p;
    repeat (d) @(negedge clk);
    strobe = 1'b1;
    @(negedge clk);
    chk("R2 released", out_en, 0);
    chk("R3 hold at rise", code_out, shown);
    line_in = ~data; pol = ~p;
    @(negedge clk);
    chk("R2 still released", out_en, 0);
    strobe = 1'b0;
    @(negedge clk);
    chk("R3 driven", out_en, 1);
    check_columns(data, p);
    shown = data;
  endtask

  function automatic logic [LW-1:0] make_line(input int base);
    logic [LW-1:0] v;
    for (int j = 0; j < NCOL; j++) v[j*CODE_W +: CODE_W] = CODE_W'((base + 9*j) % 64);
    return v;
  endfunction

  initial begin
    do_reset();
    for (int c = 0; c < 64; c++)
      for (int p = 0; p < 2; p++)
        run_line(make_line(c), p[0], SETUP_CYC);
    chk("R9 no viol with held pol", setup_viol, 0);
    run_line({8{6'h10}} ^ {4{12'h000}}, 1'b0, SETUP_CYC);
    run_line({2{6'h3F, 6'h30, 6'h20, 6'h10}}, 1'b1, SETUP_CYC);
    // idle: line_in changes without a strobe must not reach outputs (R3)
    @(negedge clk); line_in = make_line(5);
    repeat (4) @(negedge clk);
    chk("R3 idle ignored", code_out, shown);
    chk("R3 idle out_en", out_en, 1);
    run_line(make_line(7), 1'b1, SETUP_CYC);
    chk("R9 change at setup limit ok", setup_viol, 0);
    run_line(make_line(11), 1'b1, 0);
    chk("R9 change at rise", setup_viol, 1);
    run_line(make_line(13), 1'b0, SETUP_CYC + 1);
    chk("R9 sticky", setup_viol, 1);
    do_reset();
    run_line(make_line(17), 1'b1, 1);
    chk("R9 change one edge early", setup_viol, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule